// File: doc/BRIEF.md
# Interrupt Entry and System Register Unit

This unit sits at the commit stage of a pipelined processor. It keeps four system registers: a control/status word holding the interrupt enable and the saved enable, the handler entry address, the saved return address and the number of the device that caused the last interrupt. It watches a set of device request lines and combines them into one prioritised request. It decodes the system-class instructions that read a system register, write a system register or return from an interrupt.

Each cycle the pipeline presents the instruction that is committing. This is the instruction word, the correct address of the instruction that follows it, a flag that is low for a bubble, and the value of its source register. When a request is pending and a real instruction commits, the unit takes the interrupt. It saves the return address and the device number, moves the enable into the saved-enable bit and clears the enable, all in one cycle. It also tells the fetch stage to restart at the handler address.

System-register reads, writes and interrupt updates all happen in this single stage. Because that stage cannot be flushed, no forwarding of system registers is needed.

Top module: `irq_sysreg_unit`

## Requirements
- R1: While reset is asserted and after it is released, all system registers read as zero, no redirect is issued and no request is raised, even when a return instruction is presented.
- R2: `irq_req_o` is 1 exactly when reset is released, the enable bit (status bit 0) is 1 and at least one device line is high.
- R3: An interrupt is taken only in a cycle where `cmt_valid_i` is 1. On a bubble the pending request waits. A bubble also never changes any system register.
- R4: Taking an interrupt redirects fetch to the handler address register (number 1). It loads the return address register (number 2) with `cmt_next_pc_i` and sets status bit 1 to the old status bit 0 while clearing bit 0.
- R5: On a take, the device-number register (number 3) receives the priority code. Line 0 (timer) gives 1, line 1 (keys) gives 2 and line 2 (switches) gives 3. The lowest line wins. The code is 0xF when no line is active.
- R6: Return is encoded as 0xF1000000. It redirects fetch to the return address register, copies status bit 1 into bit 0 and leaves bit 1 unchanged.
- R7: Read is encoded as {4'hF, 4'h2, dest GPR, sreg, 16'h0}. It sets `sreg_rd_en_o`, puts the dest GPR on `sreg_rd_gpr_o` and the selected register on `sreg_rd_data_o`. The status word reads as bits 1:0 with the rest zero. Register numbers 4 to 15 read as zero.
- R8: Write is encoded as {4'hF, 4'h3, sreg, src GPR, 16'h0}. It stores `cmt_src_val_i` into the selected register. The status word keeps only bits 1:0, and the device number keeps only its low 4 bits. Writes to numbers 4 to 15 are ignored.
- R9: When a write or return commits, no interrupt is taken in that cycle. This holds even when a request is pending. In particular, a write that clears the enable wins over a pending request.
- R10: A system-class word with an unknown secondary opcode, or with nonzero bits where zeros are required, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq_i | input | NUM_DEV | Device request lines, bit 0 highest priority |
| cmt_valid_i | input | 1 | Committing instruction is real (0 = bubble) |
| cmt_instr_i | input | 32 | Committing instruction word |
| cmt_next_pc_i | input | XLEN | Correct address of the next instruction |
| cmt_src_val_i | input | XLEN | Source register value for system writes |
| irq_req_o | output | 1 | Prioritised interrupt request |
| redirect_o | output | 1 | Restart fetch this cycle |
| redirect_pc_o | output | XLEN | Fetch restart address |
| sreg_rd_en_o | output | 1 | A system read commits this cycle |
| sreg_rd_gpr_o | output | 4 | Destination GPR of the system read |
| sreg_rd_data_o | output | XLEN | Value read from the system register |

## Verification
The hardest situations to reach are the collisions at the commit point. These are a pending request meeting a bubble, a status write or a return committing in the very cycle a request is live, and several devices raising lines at once. The stimulus table first arms the handler address and the enable through system writes. It then holds device lines high while it feeds a bubble, a clearing write and a return on successive cycles. After each collision it reads the status word, return address and device number back through system reads, so every effect is seen at the ports.

// File: rtl/irq_sys_pkg.sv
`timescale 1ns/1ps
package irq_sys_pkg;
    localparam int INSTR_W = 32;

    localparam logic [3:0] OPC_SYS  = 4'hF;
    localparam logic [3:0] SUB_RETI = 4'h1;
    localparam logic [3:0] SUB_RSR  = 4'h2;
    localparam logic [3:0] SUB_WSR  = 4'h3;

    localparam logic [3:0] SR_PCS = 4'd0;
    localparam logic [3:0] SR_IHA = 4'd1;
    localparam logic [3:0] SR_IRA = 4'd2;
    localparam logic [3:0] SR_IDN = 4'd3;

    typedef struct packed {
        logic       reti;
        logic       rsr;
        logic       wsr;
        logic [3:0] gpr;
        logic [3:0] sreg;
    } sys_dec_t;
endpackage

// File: rtl/sys_instr_decode.sv
`timescale 1ns/1ps
module sys_instr_decode
    import irq_sys_pkg::*;
(
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    output sys_dec_t           dec_o
);
    logic       is_sys;
    logic [3:0] sub;
    logic [3:0] fa;
    logic [3:0] fb;
    logic       low_zero;

    always_comb begin
        is_sys   = valid_i && (instr_i[31:28] == OPC_SYS);
        sub      = instr_i[27:24];
        fa       = instr_i[23:20];
        fb       = instr_i[19:16];
        low_zero = (instr_i[15:0] == 16'h0);

        dec_o      = '0;
        // R10: anything not matching exactly stays a no-op
        dec_o.reti = is_sys && (sub == SUB_RETI) && (fa == 4'h0) && (fb == 4'h0) && low_zero;
        dec_o.rsr  = is_sys && (sub == SUB_RSR) && low_zero;
        dec_o.wsr  = is_sys && (sub == SUB_WSR) && low_zero;
        dec_o.gpr  = fa;
        dec_o.sreg = (sub == SUB_WSR) ? fa : fb;
    end
endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc #(
    parameter int NUM_DEV = 3,
    parameter int ID_W    = 4
) (
    input  logic [NUM_DEV-1:0] irq_i,
    output logic               any_o,
    output logic [ID_W-1:0]    code_o
);
    localparam logic [ID_W-1:0] NONE_CODE = '1;

    always_comb begin
        any_o  = |irq_i;
        code_o = NONE_CODE;
        // scan from lowest priority so the lowest line index wins (R5)
        for (int i = NUM_DEV - 1; i >= 0; i--) begin
            if (irq_i[i]) code_o = ID_W'(i + 1);
        end
    end
endmodule

// File: rtl/sysreg_file.sv
`timescale 1ns/1ps
module sysreg_file
    import irq_sys_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic            reti_i,
    input  logic            wsr_i,
    input  logic [3:0]      sreg_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic [XLEN-1:0] ret_addr_i,
    input  logic [ID_W-1:0] idn_code_i,
    output logic            ie_o,
    output logic [XLEN-1:0] iha_o,
    output logic [XLEN-1:0] ira_o,
    output logic [ID_W-1:0] idn_o,
    output logic [XLEN-1:0] rdata_o
);
    typedef struct packed {
        logic            oie;
        logic            ie;
        logic [XLEN-1:0] iha;
        logic [XLEN-1:0] ira;
        logic [ID_W-1:0] idn;
    } sreg_state_t;

    sreg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wsr_i) begin
            case (sreg_i)
                SR_PCS:  {st_d.oie, st_d.ie} = wdata_i[1:0];
                SR_IHA:  st_d.iha = wdata_i;
                SR_IRA:  st_d.ira = wdata_i;
                SR_IDN:  st_d.idn = wdata_i[ID_W-1:0];
                default: ;
            endcase
        end
        if (reti_i) st_d.ie = st_q.oie;
        if (take_i) begin
            st_d.oie = st_q.ie;
            st_d.ie  = 1'b0;
            st_d.ira = ret_addr_i;
            st_d.idn = idn_code_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (sreg_i)
            SR_PCS:  rdata_o = {{(XLEN-2){1'b0}}, st_q.oie, st_q.ie};
            SR_IHA:  rdata_o = st_q.iha;
            SR_IRA:  rdata_o = st_q.ira;
            SR_IDN:  rdata_o = {{(XLEN-ID_W){1'b0}}, st_q.idn};
            default: rdata_o = '0;
        endcase
    end

    assign ie_o  = st_q.ie;
    assign iha_o = st_q.iha;
    assign ira_o = st_q.ira;
    assign idn_o = st_q.idn;

    a_r4_take_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !st_q.ie);
    a_r4_take_saves_oie: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> st_q.oie == $past(st_q.ie));
    a_r4_take_saves_ira: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> st_q.ira == $past(ret_addr_i));
    a_r6_reti_restores: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> (st_q.ie == $past(st_q.oie)) && (st_q.oie == $past(st_q.oie)));
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_i || reti_i || wsr_i) |=> $stable(st_q));
endmodule

// File: rtl/irq_sysreg_unit.sv
`timescale 1ns/1ps
module irq_sysreg_unit
    import irq_sys_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_DEV = 3,
    parameter int ID_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DEV-1:0] dev_irq_i,
    input  logic               cmt_valid_i,
    input  logic [31:0]        cmt_instr_i,
    input  logic [XLEN-1:0]    cmt_next_pc_i,
    input  logic [XLEN-1:0]    cmt_src_val_i,
    output logic               irq_req_o,
    output logic               redirect_o,
    output logic [XLEN-1:0]    redirect_pc_o,
    output logic               sreg_rd_en_o,
    output logic [3:0]         sreg_rd_gpr_o,
    output logic [XLEN-1:0]    sreg_rd_data_o
);
    sys_dec_t        dec;
    logic            irq_any;
    logic [ID_W-1:0] irq_code;
    logic            ie;
    logic [XLEN-1:0] iha;
    logic [XLEN-1:0] ira;
    logic [ID_W-1:0] idn;
    logic            take;
    logic            live;

    assign live = rst_n && cmt_valid_i;

    sys_instr_decode u_dec (
        .valid_i (live),
        .instr_i (cmt_instr_i),
        .dec_o   (dec)
    );

    irq_prio_enc #(.NUM_DEV(NUM_DEV), .ID_W(ID_W)) u_enc (
        .irq_i  (dev_irq_i),
        .any_o  (irq_any),
        .code_o (irq_code)
    );

    always_comb begin
        irq_req_o = rst_n && ie && irq_any;
        // R3, R9: only a real, non-system-update instruction can carry the take
        take      = irq_req_o && live && !dec.wsr && !dec.reti;
        redirect_o    = take || dec.reti;
        redirect_pc_o = take ? iha : ira;
    end

    sysreg_file #(.XLEN(XLEN), .ID_W(ID_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take),
        .reti_i     (dec.reti),
        .wsr_i      (dec.wsr),
        .sreg_i     (dec.sreg),
        .wdata_i    (cmt_src_val_i),
        .ret_addr_i (cmt_next_pc_i),
        .idn_code_i (irq_code),
        .ie_o       (ie),
        .iha_o      (iha),
        .ira_o      (ira),
        .idn_o      (idn),
        .rdata_o    (sreg_rd_data_o)
    );

    assign sreg_rd_en_o  = dec.rsr;
    assign sreg_rd_gpr_o = dec.gpr;

    a_r5_idn_names_device: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> idn != '1);
    a_r3_take_on_real_instr: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && !dec.reti) |-> cmt_valid_i);
endmodule

// File: tb/tb_irq_sysreg_unit.sv
`timescale 1ns/1ps
module tb_irq_sysreg_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  dev_irq;
    logic        cmt_valid;
    logic [31:0] cmt_instr;
    logic [31:0] cmt_npc;
    logic [31:0] cmt_src;
    logic        irq_req;
    logic        redirect;
    logic [31:0] redirect_pc;
    logic        rd_en;
    logic [3:0]  rd_gpr;
    logic [31:0] rd_data;

    always #2.5 clk = ~clk;

    irq_sysreg_unit dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .dev_irq_i      (dev_irq),
        .cmt_valid_i    (cmt_valid),
        .cmt_instr_i    (cmt_instr),
        .cmt_next_pc_i  (cmt_npc),
        .cmt_src_val_i  (cmt_src),
        .irq_req_o      (irq_req),
        .redirect_o     (redirect),
        .redirect_pc_o  (redirect_pc),
        .sreg_rd_en_o   (rd_en),
        .sreg_rd_gpr_o  (rd_gpr),
        .sreg_rd_data_o (rd_data)
    );

    localparam logic [31:0] NOP    = 32'h0000_0013;
    localparam logic [31:0] RETI   = 32'hF100_0000;
    localparam logic [31:0] RD_PCS = 32'hF250_0000;
    localparam logic [31:0] RD_IHA = 32'hF251_0000;
    localparam logic [31:0] RD_IRA = 32'hF252_0000;
    localparam logic [31:0] RD_IDN = 32'hF253_0000;
    localparam logic [31:0] RD_R5  = 32'hF255_0000;
    localparam logic [31:0] WR_PCS = 32'hF301_0000;
    localparam logic [31:0] WR_IHA = 32'hF311_0000;
    localparam logic [31:0] WR_IRA = 32'hF321_0000;
    localparam logic [31:0] WR_IDN = 32'hF331_0000;
    localparam logic [31:0] WR_R5  = 32'hF351_0000;

    typedef struct packed {
        logic [3:0]  rq;
        logic [2:0]  irq;
        logic        v;
        logic [31:0] ins;
        logic [31:0] npc;
        logic [31:0] rs;
        logic        xreq;
        logic        xred;
        logic [31:0] xpc;
        logic        xrd;
        logic [31:0] xdat;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 3'b000, 1'b1, RD_PCS, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h0},            // R1
        '{4'd1, 3'b000, 1'b1, RD_IHA, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h0},            // R1
        '{4'd1, 3'b000, 1'b1, RD_IDN, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h0},            // R1
        '{4'd2, 3'b001, 1'b1, NOP,    32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},            // R2 IE=0
        '{4'd8, 3'b000, 1'b1, WR_IHA, 32'h0, 32'h100, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},          // R8
        '{4'd8, 3'b000, 1'b1, RD_IHA, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h100},          // R8
        '{4'd8, 3'b000, 1'b1, WR_PCS, 32'h0, 32'hFFFF_FFFD, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},    // R8
        '{4'd8, 3'b000, 1'b1, RD_PCS, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h1},            // R8 mask
        '{4'd3, 3'b110, 1'b0, NOP,    32'h0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0},            // R3 bubble
        '{4'd4, 3'b110, 1'b1, NOP,    32'h2000, 32'h0, 1'b1, 1'b1, 32'h100, 1'b0, 32'h0},       // R4 take
        '{4'd4, 3'b000, 1'b1, RD_IRA, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h2000},         // R4
        '{4'd4, 3'b000, 1'b1, RD_PCS, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h2},            // R4
        '{4'd5, 3'b000, 1'b1, RD_IDN, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h2},            // R5 keys
        '{4'd2, 3'b111, 1'b1, NOP,    32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},            // R2
        '{4'd6, 3'b000, 1'b1, RETI,   32'h0, 32'h0, 1'b0, 1'b1, 32'h2000, 1'b0, 32'h0},         // R6
        '{4'd6, 3'b000, 1'b1, RD_PCS, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h3},            // R6
        '{4'd9, 3'b111, 1'b1, WR_PCS, 32'h0, 32'h2, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0},            // R9 clear IE
        '{4'd9, 3'b111, 1'b1, NOP,    32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},            // R9
        '{4'd9, 3'b000, 1'b1, RD_PCS, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h2},            // R9
        '{4'd8, 3'b000, 1'b1, WR_PCS, 32'h0, 32'h1, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},            // R8
        '{4'd9, 3'b111, 1'b1, RETI,   32'h0, 32'h0, 1'b1, 1'b1, 32'h2000, 1'b0, 32'h0},         // R9 reti wins
        '{4'd9, 3'b000, 1'b1, RD_PCS, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h0},            // R9
        '{4'd8, 3'b000, 1'b1, WR_PCS, 32'h0, 32'h1, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},            // R8
        '{4'd5, 3'b101, 1'b1, NOP,    32'h3000, 32'h0, 1'b1, 1'b1, 32'h100, 1'b0, 32'h0},       // R5 timer
        '{4'd5, 3'b000, 1'b1, RD_IDN, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h1},            // R5
        '{4'd4, 3'b000, 1'b1, RD_IRA, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h3000},         // R4
        '{4'd8, 3'b000, 1'b1, WR_PCS, 32'h0, 32'h1, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},            // R8
        '{4'd5, 3'b100, 1'b1, NOP,    32'h4000, 32'h0, 1'b1, 1'b1, 32'h100, 1'b0, 32'h0},       // R5 switches
        '{4'd5, 3'b000, 1'b1, RD_IDN, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h3},            // R5
        '{4'd8, 3'b000, 1'b1, WR_R5,  32'h0, 32'hDEAD, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},         // R8 reserved
        '{4'd7, 3'b000, 1'b1, RD_R5,  32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h0},            // R7 reserved
        '{4'd10, 3'b000, 1'b1, 32'hF400_0000, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},    // R10
        '{4'd10, 3'b000, 1'b1, 32'hF253_0001, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},    // R10
        '{4'd10, 3'b000, 1'b1, 32'hF100_0010, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},    // R10
        '{4'd10, 3'b000, 1'b1, RD_PCS, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h2},           // R10
        '{4'd8, 3'b000, 1'b1, WR_IDN, 32'h0, 32'hFFFF_FFF7, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},    // R8
        '{4'd8, 3'b000, 1'b1, RD_IDN, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h7},            // R8
        '{4'd8, 3'b000, 1'b1, WR_IRA, 32'h0, 32'h5555_0000, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},    // R8
        '{4'd7, 3'b000, 1'b1, RD_IRA, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h5555_0000},    // R7
        '{4'd3, 3'b000, 1'b0, WR_IHA, 32'h0, 32'h999, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},          // R3 bubble write
        '{4'd3, 3'b000, 1'b1, RD_IHA, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h100}           // R3
    };

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] irq, input logic v, input logic [31:0] ins,
                         input logic [31:0] npc, input logic [31:0] rs);
        dev_irq   = irq;
        cmt_valid = v;
        cmt_instr = ins;
        cmt_npc   = npc;
        cmt_src   = rs;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(3'b111, 1'b1, RETI, 32'h0, 32'h0);
        repeat (2) @(negedge clk);
        #1;
        chk("R1 redirect in reset", {31'h0, redirect}, 32'h0);
        chk("R1 request in reset", {31'h0, irq_req}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(3'b000, 1'b0, NOP, 32'h0, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].irq, VECS[i].v, VECS[i].ins, VECS[i].npc, VECS[i].rs);
            #1;
            chk($sformatf("R%0d v%0d request", VECS[i].rq, i), {31'h0, irq_req}, {31'h0, VECS[i].xreq});
            chk($sformatf("R%0d v%0d redirect", VECS[i].rq, i), {31'h0, redirect}, {31'h0, VECS[i].xred});
            if (VECS[i].xred)
                chk($sformatf("R%0d v%0d target", VECS[i].rq, i), redirect_pc, VECS[i].xpc);
            chk($sformatf("R%0d v%0d read enable", VECS[i].rq, i), {31'h0, rd_en}, {31'h0, VECS[i].xrd});
            if (VECS[i].xrd) begin
                chk($sformatf("R%0d v%0d read data", VECS[i].rq, i), rd_data, VECS[i].xdat);
                chk($sformatf("R7 v%0d dest gpr", i), {28'h0, rd_gpr}, 32'h5);
            end
        end

        // R1: mid-run reset with state loaded, return word presented
        @(negedge clk);
        rst_n = 1'b0;
        drive(3'b111, 1'b1, RETI, 32'h0, 32'h0);
        #1;
        chk("R1 redirect during reset", {31'h0, redirect}, 32'h0);
        chk("R1 request during reset", {31'h0, irq_req}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(3'b000, 1'b1, RD_IHA, 32'h0, 32'h0);
        #1;
        chk("R1 IHA after reset", rd_data, 32'h0);
        @(negedge clk);
        drive(3'b000, 1'b1, RD_IRA, 32'h0, 32'h0);
        #1;
        chk("R1 IRA after reset", rd_data, 32'h0);
        @(negedge clk);
        drive(3'b000, 1'b1, RD_IDN, 32'h0, 32'h0);
        #1;
        chk("R1 IDN after reset", rd_data, 32'h0);
        @(negedge clk);
        drive(3'b111, 1'b1, RD_PCS, 32'h0, 32'h0);
        #1;
        chk("R1 PCS after reset", rd_data, 32'h0);
        chk("R2 no request with IE clear", {31'h0, irq_req}, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule